// File: doc/BRIEF.md
# Exception Entry State Controller

This block performs the status-register update a processor core needs when it accepts a synchronous exception or a debug exception. The core presents a request strobe with the faulting PC, a cause code, an optional faulting address, the current processor status word and the current interrupt level. One cycle later the block raises a single-cycle taken pulse. In the same cycle it presents the selected entry vector and the write enables and data for every status register that the entry touches.

A general exception taken with the exception-mode bit clear saves the PC to the first-level exception PC. It vectors to the user or kernel handler according to the user-mode bit. A general exception taken with the exception-mode bit already set is a double exception. It saves the PC to a dedicated double-exception PC register when one is configured, and to the first-level exception PC otherwise.

A debug request is accepted only while the current interrupt level is below the configured debug level. On acceptance the block saves the PC and the old status word into the save slots of that level. It then raises the interrupt level of the status word to the debug level. Instruction fetch, vector addresses, interrupt arbitration and pipeline flush belong to the surrounding core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, taken_o, every write enable and every bit of lvl_we_o are 0.
- R2: A general request with status bit 4 (exception mode) clear writes pc_i to the first-level PC (epc1_we_o). The vector is 1 (user) when status bit 5 (user mode) is set, and 0 (kernel) otherwise.
- R3: A general request with status bit 4 set selects vector 2 (double). The PC write goes to depc_we_o when HAS_DEPC is 1 and to epc1_we_o when HAS_DEPC is 0, never to both.
- R4: Every accepted general request writes cause_i through exccause_we_o/exccause_o. It writes the status word with bit 4 set and all other bits unchanged.
- R5: The faulting address is written (excvaddr_we_o with excvaddr_o = vaddr_i) only when vaddr_vld_i accompanies an accepted general request.
- R6: A debug request is accepted only when cur_level_i < DBG_LEVEL. Otherwise it produces no taken pulse and no write.
- R7: An accepted debug request writes cause_i to the debug cause and pc_i to the level PC. It writes the old status word to the level status save (eps_o). lvl_we_o is one-hot with bit DBG_LEVEL-1 set, and epc1_we_o and depc_we_o stay low.
- R8: On debug entry the new status word has bits [3:0] equal to DBG_LEVEL and bit 4 set, with bits [7:5] unchanged. The vector is 3 (debug).
- R9: All outputs for a request appear in the cycle after the strobe. taken_o is a single-cycle pulse for each strobe cycle, and it is low after an idle cycle.
- R10: When an accepted debug request coincides with a general request, the debug entry wins and no general-exception register (exccause, excvaddr, epc1, depc) is written. When the debug request is refused, the general request proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | General exception request strobe |
| dbg_req_i | input | 1 | Debug exception request strobe |
| pc_i | input | XLEN | Faulting PC |
| cause_i | input | CAUSE_W | Cause code (general or debug) |
| vaddr_i | input | XLEN | Faulting virtual address |
| vaddr_vld_i | input | 1 | Request carries a faulting address |
| ps_i | input | 8 | Current status word: [3:0] level, [4] exception mode, [5] user mode |
| cur_level_i | input | 4 | Current interrupt level |
| taken_o | output | 1 | Entry taken pulse |
| vec_o | output | 2 | Vector: 0 kernel, 1 user, 2 double, 3 debug |
| epc1_we_o | output | 1 | First-level PC write enable |
| depc_we_o | output | 1 | Double-exception PC write enable |
| pc_save_o | output | XLEN | PC data for any PC save register |
| exccause_we_o | output | 1 | Exception cause write enable |
| exccause_o | output | CAUSE_W | Exception cause data |
| excvaddr_we_o | output | 1 | Faulting address write enable |
| excvaddr_o | output | XLEN | Faulting address data |
| dbgcause_we_o | output | 1 | Debug cause write enable |
| dbgcause_o | output | CAUSE_W | Debug cause data |
| lvl_we_o | output | 7 | Per-level PC/status save enables, bit L-1 for level L |
| eps_o | output | 8 | Old status word for the level status save |
| ps_we_o | output | 1 | Status word write enable |
| ps_o | output | 8 | New status word |

## Verification
The embedded properties watch every cycle for the structural rules. PC saves never hit both the first-level and the double register. Level enables are one-hot or zero. A new status word always carries the exception-mode bit. No general and debug cause write share a cycle. No debug write follows a cycle whose interrupt level was at or above the debug level. Each taken pulse is preceded by a request. What only the bench shows is the data content: vector choice across every status word, address capture tied to the valid flag, the exact debug status word, priority between simultaneous requests, and the refused-request sweep over all interrupt levels.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PS_W        = 8;
  localparam int PS_LVL_W    = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
  localparam int LVL_N       = 7;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  // Status word after a general entry: exception mode forced on.
  function automatic logic [PS_W-1:0] ps_after_general(input logic [PS_W-1:0] ps);
    logic [PS_W-1:0] r;
    r = ps;
    r[PS_EXCM_BIT] = 1'b1;
    return r;
  endfunction

  // Status word after a debug entry: level replaced, exception mode on.
  function automatic logic [PS_W-1:0] ps_after_debug(input logic [PS_W-1:0] ps,
                                                     input logic [PS_LVL_W-1:0] lvl);
    logic [PS_W-1:0] r;
    r = ps;
    r[PS_LVL_W-1:0] = lvl;
    r[PS_EXCM_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_gen_path.sv
module exc_gen_path
  import exc_entry_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic [PS_W-1:0] ps_i,
  output vec_e            vec_o,
  output logic            use_epc1_o,
  output logic            use_depc_o,
  output logic [PS_W-1:0] ps_next_o
);
  logic in_exc;
  assign in_exc = ps_i[PS_EXCM_BIT];

  always_comb begin
    if (in_exc)                vec_o = VEC_DOUBLE;
    else if (ps_i[PS_UM_BIT])  vec_o = VEC_USER;
    else                       vec_o = VEC_KERNEL;
  end

  generate
    if (HAS_DEPC) begin : g_depc
      assign use_depc_o = in_exc;
      assign use_epc1_o = !in_exc;
    end else begin : g_no_depc
      assign use_depc_o = 1'b0;
      assign use_epc1_o = 1'b1;
    end
  endgenerate

  assign ps_next_o = ps_after_general(ps_i);
endmodule

// File: rtl/exc_dbg_path.sv
module exc_dbg_path
  import exc_entry_pkg::*;
#(
  parameter int DBG_LEVEL = 4
) (
  input  logic                dbg_req_i,
  input  logic [PS_LVL_W-1:0] cur_level_i,
  input  logic [PS_W-1:0]     ps_i,
  output logic                take_o,
  output logic [LVL_N-1:0]    lvl_sel_o,
  output logic [PS_W-1:0]     ps_next_o
);
  localparam logic [PS_LVL_W-1:0] DLVL = PS_LVL_W'(DBG_LEVEL);

  assign take_o    = dbg_req_i && (cur_level_i < DLVL);
  assign ps_next_o = ps_after_debug(ps_i, DLVL);

  // Save slot for level L sits at bit L-1; fixed at elaboration.
  for (genvar i = 0; i < LVL_N; i++) begin : g_lvl
    assign lvl_sel_o[i] = (i == DBG_LEVEL - 1);
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBG_LEVEL = 4,   // legal range 2..6
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               dbg_req_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    vaddr_i,
  input  logic               vaddr_vld_i,
  input  logic [7:0]         ps_i,
  input  logic [3:0]         cur_level_i,
  output logic               taken_o,
  output logic [1:0]         vec_o,
  output logic               epc1_we_o,
  output logic               depc_we_o,
  output logic [XLEN-1:0]    pc_save_o,
  output logic               exccause_we_o,
  output logic [CAUSE_W-1:0] exccause_o,
  output logic               excvaddr_we_o,
  output logic [XLEN-1:0]    excvaddr_o,
  output logic               dbgcause_we_o,
  output logic [CAUSE_W-1:0] dbgcause_o,
  output logic [6:0]         lvl_we_o,
  output logic [7:0]         eps_o,
  output logic               ps_we_o,
  output logic [7:0]         ps_o
);
  // Named internal events
  vec_e             gen_vec;
  logic             gen_use_epc1, gen_use_depc;
  logic [PS_W-1:0]  gen_ps, dbg_ps;
  logic             dbg_go, gen_go, any_go;
  logic [LVL_N-1:0] dbg_lvl_sel;

  exc_gen_path #(.HAS_DEPC(HAS_DEPC)) u_gen (
    .ps_i       (ps_i),
    .vec_o      (gen_vec),
    .use_epc1_o (gen_use_epc1),
    .use_depc_o (gen_use_depc),
    .ps_next_o  (gen_ps)
  );

  exc_dbg_path #(.DBG_LEVEL(DBG_LEVEL)) u_dbg (
    .dbg_req_i   (dbg_req_i),
    .cur_level_i (cur_level_i),
    .ps_i        (ps_i),
    .take_o      (dbg_go),
    .lvl_sel_o   (dbg_lvl_sel),
    .ps_next_o   (dbg_ps)
  );

  assign gen_go = req_i && !dbg_go;
  assign any_go = gen_go || dbg_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o       <= 1'b0;
      vec_o         <= 2'd0;
      epc1_we_o     <= 1'b0;
      depc_we_o     <= 1'b0;
      pc_save_o     <= '0;
      exccause_we_o <= 1'b0;
      exccause_o    <= '0;
      excvaddr_we_o <= 1'b0;
      excvaddr_o    <= '0;
      dbgcause_we_o <= 1'b0;
      dbgcause_o    <= '0;
      lvl_we_o      <= '0;
      eps_o         <= '0;
      ps_we_o       <= 1'b0;
      ps_o          <= '0;
    end else begin
      taken_o       <= any_go;
      epc1_we_o     <= gen_go && gen_use_epc1;
      depc_we_o     <= gen_go && gen_use_depc;
      exccause_we_o <= gen_go;
      excvaddr_we_o <= gen_go && vaddr_vld_i;
      dbgcause_we_o <= dbg_go;
      lvl_we_o      <= dbg_go ? dbg_lvl_sel : '0;
      ps_we_o       <= any_go;
      if (any_go) begin
        vec_o     <= dbg_go ? VEC_DEBUG : gen_vec;
        pc_save_o <= pc_i;
        ps_o      <= dbg_go ? dbg_ps : gen_ps;
      end
      if (gen_go) exccause_o <= cause_i;
      if (gen_go && vaddr_vld_i) excvaddr_o <= vaddr_i;
      if (dbg_go) begin
        dbgcause_o <= cause_i;
        eps_o      <= ps_i;
      end
    end
  end

  // Assertions
  assert_pc_save_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(epc1_we_o && depc_we_o));
  assert_lvl_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_we_o));
  assert_ps_excm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_we_o |-> ps_o[PS_EXCM_BIT]);
  assert_cause_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(exccause_we_o && dbgcause_we_o));
  assert_dbg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_go |=> (dbgcause_we_o && lvl_we_o != '0));
  assert_dbg_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level_i >= 4'(DBG_LEVEL)) |=> !dbgcause_we_o);
  assert_taken_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i || dbg_req_i) |=> !taken_o);
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam int DL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, dbg_req_i = 1'b0, vaddr_vld_i = 1'b0;
  logic [31:0] pc_i = '0, vaddr_i = '0;
  logic [5:0]  cause_i = '0;
  logic [7:0]  ps_i = '0;
  logic [3:0]  cur_level_i = '0;

  logic        taken_o, epc1_we_o, depc_we_o, exccause_we_o, excvaddr_we_o;
  logic        dbgcause_we_o, ps_we_o;
  logic [1:0]  vec_o;
  logic [31:0] pc_save_o, excvaddr_o;
  logic [5:0]  exccause_o, dbgcause_o;
  logic [6:0]  lvl_we_o;
  logic [7:0]  eps_o, ps_o;

  logic        nd_epc1_we, nd_depc_we, nd_taken, nd_exccause_we, nd_excvaddr_we;
  logic        nd_dbgcause_we, nd_ps_we;
  logic [1:0]  nd_vec;
  logic [31:0] nd_pc, nd_excvaddr;
  logic [5:0]  nd_exccause, nd_dbgcause;
  logic [6:0]  nd_lvl;
  logic [7:0]  nd_eps, nd_ps;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DEPC(1'b1)) u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .dbg_req_i(dbg_req_i), .pc_i(pc_i),
    .cause_i(cause_i), .vaddr_i(vaddr_i), .vaddr_vld_i(vaddr_vld_i), .ps_i(ps_i),
    .cur_level_i(cur_level_i), .taken_o(taken_o), .vec_o(vec_o),
    .epc1_we_o(epc1_we_o), .depc_we_o(depc_we_o), .pc_save_o(pc_save_o),
    .exccause_we_o(exccause_we_o), .exccause_o(exccause_o),
    .excvaddr_we_o(excvaddr_we_o), .excvaddr_o(excvaddr_o),
    .dbgcause_we_o(dbgcause_we_o), .dbgcause_o(dbgcause_o), .lvl_we_o(lvl_we_o),
    .eps_o(eps_o), .ps_we_o(ps_we_o), .ps_o(ps_o));

  exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DEPC(1'b0)) u_exc_entry_ctrl_nd (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .dbg_req_i(dbg_req_i), .pc_i(pc_i),
    .cause_i(cause_i), .vaddr_i(vaddr_i), .vaddr_vld_i(vaddr_vld_i), .ps_i(ps_i),
    .cur_level_i(cur_level_i), .taken_o(nd_taken), .vec_o(nd_vec),
    .epc1_we_o(nd_epc1_we), .depc_we_o(nd_depc_we), .pc_save_o(nd_pc),
    .exccause_we_o(nd_exccause_we), .exccause_o(nd_exccause),
    .excvaddr_we_o(nd_excvaddr_we), .excvaddr_o(nd_excvaddr),
    .dbgcause_we_o(nd_dbgcause_we), .dbgcause_o(nd_dbgcause), .lvl_we_o(nd_lvl),
    .eps_o(nd_eps), .ps_we_o(nd_ps_we), .ps_o(nd_ps));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_i = 0; dbg_req_i = 0; vaddr_vld_i = 0;
    @(posedge clk); #1;
    check("R9 taken low after idle", taken_o, 1'b0);
    check("R9 ps_we low after idle", ps_we_o, 1'b0);
    check("R9 lvl_we low after idle", lvl_we_o, 7'd0);
  endtask

  // One request; expected values follow the requirements directly.
  task automatic run_one(input logic g, input logic d, input logic [7:0] ps,
                         input logic [3:0] lvl, input logic vv,
                         input logic [31:0] pc, input logic [5:0] cs,
                         input logic [31:0] va);
    logic dt, gt;
    logic [1:0] ev;
    logic [7:0] eps_new;
    @(negedge clk);
    req_i = g; dbg_req_i = d; ps_i = ps; cur_level_i = lvl; vaddr_vld_i = vv;
    pc_i = pc; cause_i = cs; vaddr_i = va;
    dt = d && (lvl < DL);
    gt = g && !dt;
    if (dt) ev = 2'd3;
    else if (ps[4]) ev = 2'd2;
    else if (ps[5]) ev = 2'd1;
    else ev = 2'd0;
    @(posedge clk); #1;
    check("R9 taken", taken_o, dt || gt);
    check("R6 debug accepted", dbgcause_we_o, dt);
    check("R10 exccause we", exccause_we_o, gt);
    check("R5 excvaddr we", excvaddr_we_o, gt && vv);
    check("R2 epc1 we", epc1_we_o, gt && !ps[4]);
    check("R3 depc we", depc_we_o, gt && ps[4]);
    check("R3 nodepc epc1 we", nd_epc1_we, gt);
    check("R3 nodepc depc we", nd_depc_we, 1'b0);
    check("R7 lvl_we", lvl_we_o, dt ? (7'd1 << (DL - 1)) : 7'd0);
    if (dt || gt) begin
      check("R2 vector", vec_o, ev);
      check("R2 pc data", pc_save_o, pc);
      check("R4 ps we", ps_we_o, 1'b1);
    end
    if (gt) begin
      check("R4 cause data", exccause_o, cs);
      check("R4 ps data", ps_o, ps | 8'h10);
      if (vv) check("R5 vaddr data", excvaddr_o, va);
    end
    if (dt) begin
      eps_new = {ps[7:5], 1'b1, 4'(DL)};
      check("R7 dbg cause", dbgcause_o, cs);
      check("R7 eps old ps", eps_o, ps);
      check("R8 debug ps", ps_o, eps_new);
      check("R8 debug vector", vec_o, 2'd3);
    end
    if (!dt && !gt) check("R6 ignored ps_we", ps_we_o, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 taken in reset", taken_o, 1'b0);
    check("R1 ps_we in reset", ps_we_o, 1'b0);
    check("R1 lvl_we in reset", lvl_we_o, 7'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 taken after reset", taken_o, 1'b0);
    check("R1 exccause_we after reset", exccause_we_o, 1'b0);
    check("R1 epc1 after reset", epc1_we_o, 1'b0);

    // R2 R3 R4 R5: every status word, address flag alternating
    for (int p = 0; p < 256; p++) begin
      run_one(1'b1, 1'b0, 8'(p), 4'd0, p[0] ^ p[6], 32'h1000_0000 + 32'(p * 4),
              6'(p % 40), 32'hA000_0000 ^ 32'(p * 1001));
      if (p % 16 == 0) idle_check();
    end
    // R6 R7 R8 R10: debug across all levels, alone and with a general request
    for (int l = 0; l < 8; l++) begin
      for (int p = 0; p < 64; p += 7) begin
        run_one(1'b0, 1'b1, 8'(p * 3 + 1), 4'(l), 1'b1, 32'h2000_0000 + 32'(l * 64 + p),
                6'(l + p), 32'hB000_0000 + 32'(p));
        run_one(1'b1, 1'b1, 8'(p * 5), 4'(l), 1'b1, 32'h3000_0000 + 32'(l * 64 + p),
                6'(p), 32'hC000_0000 + 32'(l));
      end
      idle_check();
    end
    // R9: back-to-back strobes then idle
    run_one(1'b1, 1'b0, 8'h00, 4'd0, 1'b0, 32'h4000_0000, 6'd1, 32'h0);
    run_one(1'b1, 1'b0, 8'h20, 4'd0, 1'b0, 32'h4000_0004, 6'd2, 32'h0);
    idle_check();
    finish_run();
  end
endmodule